// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block judges whether a phase-locked loop has settled by looking at one phase-error sample per phase-detector comparison. Each sample arrives on a valid/ready stream as an unsigned magnitude in delay-tap units. The block adds a programmed detector delay to the sample and compares the sum against a programmed tolerance. Consecutive passing samples raise a digital lock flag. Failing samples lower it. Separate pass and error thresholds give hysteresis, so the flag does not chatter.

A second flag, the combined lock, guards against a false lock report when the reference clock vanishes and no more comparisons occur. It is high only when three things hold: the digital flag is high, an external charge-pump window comparator reports in range, and a reference watchdog has seen a strobe recently. The combined flag drives one of several general-purpose output pins, chosen by a select input.

The stream never applies back-pressure. `err_ready` is held high, so every cycle with `err_valid` high is one accepted comparison. The producer may present a new sample every cycle. While `err_valid` is low, `err_mag` is ignored.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `dig_lock` and `comb_lock` are low, all `lock_pin` bits are 0, and both internal counts are zero.
- R2: An accepted sample fails when the unsigned sum `err_mag + det_delay` is greater than `tol`. Otherwise it passes, so a sum equal to `tol` passes.
- R3: `dig_lock` goes high on the clock edge that accepts the passing sample that brings the consecutive-pass count to `pass_thr`.
- R4: Reaching the pass threshold also clears the accumulated failure count to zero.
- R5: `dig_lock` goes low on the clock edge that accepts the failing sample that brings the failure count to `fail_thr`. Failures are counted since the last clear, whether or not they are consecutive.
- R6: A failing sample clears the pass count, so only unbroken runs of passes count toward lock.
- R7: A threshold of 0 on `pass_thr` or `fail_thr` behaves exactly like 1. Both counts saturate at their thresholds.
- R8: `err_ready` is always 1. A cycle with `err_valid` low changes no state, whatever the value of `err_mag`.
- R9: `comb_lock` = `dig_lock` AND `cp_in_window` AND (reference active).
- R10: The reference counts as inactive once `ref_timeout` clock edges (0 behaves as 1) pass with no accepted sample. The next accepted sample makes it active again from the following cycle.
- R11: `lock_pin[route_sel]` carries `comb_lock`. Every other `lock_pin` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Phase-error sample valid |
| err_ready | output | 1 | Always high, no back-pressure |
| err_mag | input | 10 | Unsigned phase-error magnitude (taps) |
| det_delay | input | 10 | Detector delay offset added to each sample |
| tol | input | 10 | Pass tolerance |
| pass_thr | input | 10 | Consecutive passes needed for lock |
| fail_thr | input | 10 | Failures needed for unlock |
| ref_timeout | input | 16 | Idle cycles before the reference is deemed lost |
| cp_in_window | input | 1 | Charge-pump voltage lies between the low and high comparator thresholds |
| route_sel | input | 2 | Output pin index for the combined flag |
| dig_lock | output | 1 | Digital lock flag |
| comb_lock | output | 1 | Combined lock flag |
| lock_pin | output | 4 | Routed combined flag, one-hot or zero |

## Verification
A single sequence of samples steps the detector through several patterns. Passing runs that lock it are followed by scattered failures that unlock it. Other failures are separated by a full passing run, and they show whether the failure count really clears. Short pass runs broken by one failure show whether the pass count is consecutive. Samples that sit exactly at the tolerance and one tap above it fix the comparison boundary. A changed detector delay shows that the offset takes part in that comparison. An idle gap shorter or longer than the timeout, and a lowered window flag, show which condition drops the combined flag. Zero thresholds and several select values check the threshold clamp and the pin routing.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam int CNT_W = 10;
  typedef enum logic { VERDICT_PASS = 1'b0, VERDICT_FAIL = 1'b1 } verdict_t;
endpackage

// File: rtl/lkd_judge.sv
module lkd_judge
  import lkd_pkg::*;
#(
  parameter int ERR_W = 10
) (
  input  logic [ERR_W-1:0] mag,
  input  logic [ERR_W-1:0] delay,
  input  logic [ERR_W-1:0] limit,
  output verdict_t         verdict
);
  localparam int SUM_W = ERR_W + 1;
  logic [SUM_W-1:0] total;

  always_comb begin
    total   = SUM_W'(mag) + SUM_W'(delay);
    verdict = (total > SUM_W'(limit)) ? VERDICT_FAIL : VERDICT_PASS;
  end

  always_comb begin
    if (verdict == VERDICT_PASS)
      assert_pass_in_tol_R2: assert (({1'b0, mag} + {1'b0, delay}) <= {1'b0, limit});
  end
endmodule

// File: rtl/lkd_tally.sv
module lkd_tally
  import lkd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  verdict_t         verdict,
  input  logic [CNT_W-1:0] pass_thr,
  input  logic [CNT_W-1:0] fail_thr,
  output logic             locked
);
  logic [CNT_W-1:0] pass_cnt, fail_cnt;
  logic [CNT_W-1:0] pass_lim, fail_lim;
  logic [CNT_W:0]   pass_nxt, fail_nxt;
  logic             pass_hit, fail_hit;

  always_comb begin
    pass_lim = (pass_thr == '0) ? CNT_W'(1) : pass_thr;
    fail_lim = (fail_thr == '0) ? CNT_W'(1) : fail_thr;
    pass_nxt = {1'b0, pass_cnt} + 1'b1;
    fail_nxt = {1'b0, fail_cnt} + 1'b1;
    pass_hit = pass_nxt >= {1'b0, pass_lim};
    fail_hit = fail_nxt >= {1'b0, fail_lim};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_cnt <= '0;
      fail_cnt <= '0;
      locked   <= 1'b0;
    end else if (strobe) begin
      if (verdict == VERDICT_FAIL) begin
        pass_cnt <= '0;
        if (fail_hit) begin
          fail_cnt <= fail_lim;
          locked   <= 1'b0;
        end else begin
          fail_cnt <= fail_nxt[CNT_W-1:0];
        end
      end else begin
        if (pass_hit) begin
          pass_cnt <= pass_lim;
          fail_cnt <= '0;
          locked   <= 1'b1;
        end else begin
          pass_cnt <= pass_nxt[CNT_W-1:0];
        end
      end
    end
  end

  assert_unlock_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && verdict == VERDICT_FAIL && fail_hit) |=> !locked);
  assert_lock_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && verdict == VERDICT_PASS && pass_hit) |=> locked);
  assert_fail_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && verdict == VERDICT_PASS && pass_hit) |=> (fail_cnt == '0));
  assert_pass_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && verdict == VERDICT_FAIL) |=> (pass_cnt == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(locked) && $stable(pass_cnt) && $stable(fail_cnt)));
endmodule

// File: rtl/lkd_ref_watch.sv
module lkd_ref_watch #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [TO_W-1:0] timeout,
  output logic            ref_alive
);
  logic [TO_W-1:0] idle_cnt;
  logic [TO_W-1:0] to_lim;
  logic            stale;

  always_comb begin
    to_lim    = (timeout == '0) ? TO_W'(1) : timeout;
    stale     = idle_cnt >= to_lim;
    ref_alive = !stale;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (strobe)
      idle_cnt <= '0;
    else if (!stale)
      idle_cnt <= idle_cnt + 1'b1;
  end

  assert_strobe_revives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ref_alive);
  assert_idle_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !stale) |=> (idle_cnt == $past(idle_cnt) + 1'b1));
endmodule

// File: rtl/lkd_route.sv
module lkd_route #(
  parameter int NPIN = 4,
  localparam int SEL_W = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag,
  input  logic [SEL_W-1:0] sel,
  output logic [NPIN-1:0]  pins
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pins[i] = flag && (sel == SEL_W'(i));
  end

  assert_onehot_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pins));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lkd_pkg::*;
#(
  parameter int TO_W  = 16,
  parameter int NPIN  = 4,
  localparam int SEL_W = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [CNT_W-1:0] err_mag,
  input  logic [CNT_W-1:0] det_delay,
  input  logic [CNT_W-1:0] tol,
  input  logic [CNT_W-1:0] pass_thr,
  input  logic [CNT_W-1:0] fail_thr,
  input  logic [TO_W-1:0]  ref_timeout,
  input  logic             cp_in_window,
  input  logic [SEL_W-1:0] route_sel,
  output logic             dig_lock,
  output logic             comb_lock,
  output logic [NPIN-1:0]  lock_pin
);
  verdict_t verdict;
  logic     strobe;
  logic     ref_alive;

  assign err_ready = 1'b1;
  assign strobe    = err_valid && err_ready;

  lkd_judge #(.ERR_W(CNT_W)) u_judge (
    .mag(err_mag), .delay(det_delay), .limit(tol), .verdict(verdict)
  );

  lkd_tally u_tally (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .verdict(verdict),
    .pass_thr(pass_thr), .fail_thr(fail_thr), .locked(dig_lock)
  );

  lkd_ref_watch #(.TO_W(TO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .timeout(ref_timeout),
    .ref_alive(ref_alive)
  );

  assign comb_lock = dig_lock && cp_in_window && ref_alive;

  lkd_route #(.NPIN(NPIN)) u_route (
    .clk(clk), .rst_n(rst_n), .flag(comb_lock), .sel(route_sel), .pins(lock_pin)
  );

  assert_comb_needs_dig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    comb_lock |-> (dig_lock && cp_in_window));
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (!dig_lock && lock_pin == '0));
endmodule

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic        err_ready;
  logic [9:0]  err_mag = '0;
  logic [9:0]  det_delay = 10'd4;
  logic [9:0]  tol = 10'd20;
  logic [9:0]  pass_thr = 10'd3;
  logic [9:0]  fail_thr = 10'd2;
  logic [15:0] ref_timeout = 16'd100;
  logic        cp_in_window = 1'b1;
  logic [1:0]  route_sel = 2'd0;
  logic        dig_lock, comb_lock;
  logic [3:0]  lock_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pll_lock_detect uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_mag(err_mag), .det_delay(det_delay), .tol(tol), .pass_thr(pass_thr),
    .fail_thr(fail_thr), .ref_timeout(ref_timeout), .cp_in_window(cp_in_window),
    .route_sel(route_sel), .dig_lock(dig_lock), .comb_lock(comb_lock),
    .lock_pin(lock_pin)
  );

  // {valid, err_mag, cp_in_window, expected dig_lock, expected comb_lock}
  // delay 4, tolerance 20, pass threshold 3, fail threshold 2
  localparam logic [13:0] VEC [0:22] = '{
    {1'b1, 10'd10,   1'b1, 1'b0, 1'b0},  // R3 pass 1
    {1'b1, 10'd10,   1'b1, 1'b0, 1'b0},  // pass 2
    {1'b1, 10'd16,   1'b1, 1'b1, 1'b1},  // R2 sum==tol passes, R3 lock
    {1'b1, 10'd17,   1'b1, 1'b1, 1'b1},  // R2 sum=21 fails, fail 1
    {1'b1, 10'd0,    1'b1, 1'b1, 1'b1},  // pass, no clear of fail count
    {1'b1, 10'd17,   1'b1, 1'b0, 1'b0},  // R5 fail 2 unlocks
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},
    {1'b1, 10'd5,    1'b1, 1'b1, 1'b1},  // relock, R4 clears fails
    {1'b1, 10'd30,   1'b1, 1'b1, 1'b1},  // fail 1
    {1'b1, 10'd5,    1'b1, 1'b1, 1'b1},
    {1'b1, 10'd5,    1'b1, 1'b1, 1'b1},
    {1'b1, 10'd5,    1'b1, 1'b1, 1'b1},  // R4 run clears fail count
    {1'b1, 10'd500,  1'b1, 1'b1, 1'b1},  // only fail 1 after clear
    {1'b0, 10'd1000, 1'b1, 1'b1, 1'b1},  // R8 idle sample ignored
    {1'b1, 10'd5,    1'b0, 1'b1, 1'b0},  // R9 window low
    {1'b1, 10'd40,   1'b0, 1'b0, 1'b0},  // R5 fail 2 unlocks
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},
    {1'b1, 10'd21,   1'b1, 1'b0, 1'b0},  // R6 fail breaks run
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},
    {1'b1, 10'd5,    1'b1, 1'b0, 1'b0},  // only 2 consecutive
    {1'b1, 10'd5,    1'b1, 1'b1, 1'b1}   // third consecutive locks
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic sample(input logic v, input logic [9:0] m);
    err_valid = v;
    err_mag   = m;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset dig_lock", {3'b0, dig_lock}, 4'b0);
    check("R1 reset comb_lock", {3'b0, comb_lock}, 4'b0);
    check("R1 reset lock_pin", lock_pin, 4'b0);
    check("R8 err_ready high", {3'b0, err_ready}, 4'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk covering R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 23; i++) begin
      cp_in_window = VEC[i][2];
      sample(VEC[i][13], VEC[i][12:3]);
      check($sformatf("R3 R5 vector %0d dig_lock", i), {3'b0, dig_lock}, {3'b0, VEC[i][1]});
      check($sformatf("R9 vector %0d comb_lock", i), {3'b0, comb_lock}, {3'b0, VEC[i][0]});
    end

    // R11 routing
    route_sel = 2'd2;
    #1 check("R11 pin 2", lock_pin, 4'b0100);
    route_sel = 2'd0;
    #1 check("R11 pin 0", lock_pin, 4'b0001);
    cp_in_window = 1'b0;
    #1 check("R11 R9 window low", lock_pin, 4'b0000);
    cp_in_window = 1'b1;

    // R10 reference watchdog, timeout 5
    ref_timeout = 16'd5;
    sample(1'b1, 10'd5);
    check("R10 fresh strobe", {3'b0, comb_lock}, 4'b1);
    repeat (4) @(negedge clk);
    check("R10 within timeout", {3'b0, comb_lock}, 4'b1);
    @(negedge clk);
    check("R10 timed out comb", {3'b0, comb_lock}, 4'b0);
    check("R10 timed out dig", {3'b0, dig_lock}, 4'b1);
    sample(1'b1, 10'd5);
    check("R10 revived", {3'b0, comb_lock}, 4'b1);

    // R7 zero thresholds behave as one
    pass_thr = 10'd0;
    fail_thr = 10'd0;
    sample(1'b1, 10'd300);
    check("R7 single fail unlocks", {3'b0, dig_lock}, 4'b0);
    sample(1'b1, 10'd1);
    check("R7 single pass locks", {3'b0, dig_lock}, 4'b1);

    // R2 detector delay participates
    det_delay = 10'd5;
    sample(1'b1, 10'd16);
    check("R2 delay 5 fails", {3'b0, dig_lock}, 4'b0);
    det_delay = 10'd4;
    sample(1'b1, 10'd16);
    check("R2 delay 4 passes", {3'b0, dig_lock}, 4'b1);

    // R1 reset again while locked
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears lock", {2'b0, dig_lock, comb_lock}, 4'b0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule